// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block gives a processor 24 general purpose I/O lines arranged as three byte-wide ports. Ports A and B are whole bytes. Port C is split into an upper and a lower nibble. The lines fall into two groups of twelve. Group A holds port A and port C bits 7:4. Group B holds port B and port C bits 3:0. The processor reaches the block through an 8-bit data bus, a 2-bit address, and active-low chip-select, read and write strobes. The data bus is split into input, output and output-enable signals, so the tri-state buffers sit in the pad ring.

A control word sets each port or nibble to input or output. It also records a group mode for each group (basic, strobed or bidirectional). Only the mode bits are decoded and stored; the pin directions come from the direction bits in every mode. The control word can be read back. A second form of the control word sets or clears one bit of port C.

All strobe inputs are sampled on the block clock. A bus write is taken when the first of the write strobe and chip-select returns high. A mode-set write clears the ports while the strobe is still low.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset the control word reads 0x9B, all output latches are 0, every pin enable is 0, and `d_oe` is 0.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control word, for both reads and writes.
- R3: In a mode-set word (bit 7 = 1), bit 4 is the port A direction, bit 3 is the port C upper direction, bit 1 is the port B direction and bit 0 is the port C lower direction. A 1 means input. A port's enable is 1 only while that port is an output.
- R4: A read of an input port or nibble returns the live pin values. A read of an output port or nibble returns its output latch.
- R5: A write takes the data present while both `cs_n` and `wr_n` were low. It completes when the first of the two strobes rises. Data that changes after that rise is ignored. Results appear at the ports within three clock cycles of the rise.
- R6: While a mode-set write is still held low, every output latch reads 0 and every pin enable is 0. On release the new directions take effect and the latches stay 0.
- R7: A control write with bit 7 = 0 sets port C bit number bits 3:1 to the value of bit 0. It leaves the stored control word and all other latch bits unchanged.
- R8: `d_oe` is 1 only while `cs_n` and `rd_n` are both low (delayed by two clocks). When `d_oe` is 0, `d_out` is 0.
- R9: The group A mode output gives 0 for bits 6:5 = 00, 1 for 01 and 2 for 1x. The group B mode output equals bit 2 of the stored word.
- R10: Strobe activity while `cs_n` is high changes no latch, direction or control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| d_in | input | 8 | Data bus from the processor |
| d_out | output | 8 | Data bus to the processor |
| d_oe | output | 1 | Data bus drive enable |
| pa_in | input | 8 | Port A pins, inbound |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A pin enable |
| pb_in | input | 8 | Port B pins, inbound |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B pin enable |
| pc_in | input | 8 | Port C pins, inbound |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 2 | Port C enables: bit 1 upper nibble, bit 0 lower nibble |
| grp_a_mode | output | 2 | Decoded group A mode (0 basic, 1 strobed, 2 bidirectional) |
| grp_b_mode | output | 1 | Group B mode (0 basic, 1 strobed) |

## Verification
A wrong stored control word shows up on the pin enables within one clock of the commit. It also shows up the next time address 3 is read, because that read returns the word itself. A latch that misses a write, or takes late data, appears on the port output bus two to three clocks after the strobe rises. A read that returns the wrong source shows up as a mismatch between the pin value and the latch value. The clear during a mode-set write can be observed within two clocks while the strobe is still low, so a design that clears only on release is caught before the write ends.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

  localparam int CW_W = 8;

  localparam logic [1:0] SEL_PORT_A = 2'd0;
  localparam logic [1:0] SEL_PORT_B = 2'd1;
  localparam logic [1:0] SEL_PORT_C = 2'd2;
  localparam logic [1:0] SEL_CTRL   = 2'd3;

  localparam logic [CW_W-1:0] RESET_CW = 8'h9B;

  // control word bit positions (decoded by the port groups)
  localparam int CW_MODESET = 7;
  localparam int CW_AMODE_H = 6;
  localparam int CW_AMODE_L = 5;
  localparam int CW_DIR_A   = 4;
  localparam int CW_DIR_CU  = 3;
  localparam int CW_BMODE   = 2;
  localparam int CW_DIR_B   = 1;
  localparam int CW_DIR_CL  = 0;

  typedef enum logic [1:0] {
    GMODE_BASIC   = 2'd0,
    GMODE_STROBED = 2'd1,
    GMODE_BIDIR   = 2'd2
  } gmode_e;

  function automatic gmode_e decode_a_mode(input logic [CW_W-1:0] cw);
    if (cw[CW_AMODE_H])      return GMODE_BIDIR;
    else if (cw[CW_AMODE_L]) return GMODE_STROBED;
    else                     return GMODE_BASIC;
  endfunction

endpackage

// File: rtl/ppio_bus_sync.sv
module ppio_bus_sync #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  output logic              wr_act,
  output logic              rd_act,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_din,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);

  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act   <= 1'b0;
      rd_act   <= 1'b0;
      act_q    <= 1'b0;
      s_addr   <= '0;
      s_din    <= '0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      wr_act <= !cs_n && !wr_n;
      rd_act <= !cs_n && !rd_n;
      s_addr <= addr;
      s_din  <= d_in;
      act_q  <= wr_act;
      if (wr_act) begin
        cap_addr <= s_addr;
        cap_data <= s_din;
      end
    end
  end

  // the write ends when either strobe rises, whichever is first
  assign commit = act_q && !wr_act;

  a_r10_no_commit_unselected: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 2) |-> !commit);

endmodule

// File: rtl/ppio_ctrl_reg.sv
module ppio_ctrl_reg
  import ppio_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [CW_W-1:0]   s_din,
  input  logic              commit,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [CW_W-1:0]   cap_data,
  output logic [CW_W-1:0]   cw,
  output logic              clearing,
  output logic              bsr_en,
  output logic [SEL_W-1:0]  bsr_sel,
  output logic              bsr_val,
  output logic [1:0]        grp_a_mode,
  output logic              grp_b_mode
);

  logic cw_commit;
  gmode_e a_mode;

  assign cw_commit = commit && (cap_addr == SEL_CTRL) && cap_data[CW_MODESET];
  assign bsr_en    = commit && (cap_addr == SEL_CTRL) && !cap_data[CW_MODESET];
  assign bsr_sel   = cap_data[SEL_W:1];
  assign bsr_val   = cap_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cw       <= RESET_CW;
      clearing <= 1'b0;
    end else begin
      // ports are held cleared for as long as a mode-set write is low
      clearing <= wr_act && (s_addr == SEL_CTRL) && s_din[CW_MODESET];
      if (cw_commit) cw <= cap_data;
    end
  end

  assign a_mode     = decode_a_mode(cw);
  assign grp_a_mode = a_mode;
  assign grp_b_mode = cw[CW_BMODE];

  a_r1_reset_ctrl: assert property (@(posedge clk)
    $past(rst) |-> (cw == RESET_CW));

  a_r7_bsr_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    bsr_en |=> $stable(cw));

endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
  parameter int W       = 8,
  parameter int LSB_IDX = 0,
  parameter bit HAS_BSR = 1'b0,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             bsr_en,
  input  logic [SEL_W-1:0] bsr_sel,
  input  logic             bsr_val,
  input  logic             dir_in,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     lat,
  output logic             oe,
  output logic [W-1:0]     rd_val
);

  logic [W-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat   <= '0;
      oe    <= 1'b0;
      pin_q <= '0;
    end else begin
      pin_q <= pin_in;
      oe    <= !clear && !dir_in;
      if (clear) begin
        lat <= '0;
      end else if (wr_en) begin
        lat <= wr_data;
      end else if (HAS_BSR && bsr_en) begin
        for (int i = 0; i < W; i++) begin
          if (bsr_sel == SEL_W'(LSB_IDX + i)) lat[i] <= bsr_val;
        end
      end
    end
  end

  assign rd_val = dir_in ? pin_q : lat;

  a_r6_clear_empties_port: assert property (@(posedge clk) disable iff (rst)
    clear |=> ((lat == '0) && !oe));

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] d_in,
  output logic [PORT_W-1:0] d_out,
  output logic              d_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic              pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [1:0]        pc_oe,
  output logic [1:0]        grp_a_mode,
  output logic              grp_b_mode
);

  localparam int NIB_W = PORT_W / 2;
  localparam int SEL_W = $clog2(PORT_W);

  logic              wr_act, rd_act, commit, clearing;
  logic [ADDR_W-1:0] s_addr, cap_addr;
  logic [PORT_W-1:0] s_din, cap_data, cw;
  logic              bsr_en, bsr_val;
  logic [SEL_W-1:0]  bsr_sel;
  logic [PORT_W-1:0] rd_a, rd_b, rd_c, rd_mux;
  logic [1:0]        c_dir;

  ppio_bus_sync #(.DATA_W(PORT_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .d_in(d_in), .wr_act(wr_act), .rd_act(rd_act),
    .s_addr(s_addr), .s_din(s_din), .commit(commit),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  ppio_ctrl_reg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_act(wr_act), .s_addr(s_addr), .s_din(s_din),
    .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data), .cw(cw),
    .clearing(clearing), .bsr_en(bsr_en), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  ppio_port #(.W(PORT_W), .LSB_IDX(0), .HAS_BSR(1'b0), .SEL_W(SEL_W)) u_pa (
    .clk(clk), .rst(rst), .clear(clearing),
    .wr_en(commit && (cap_addr == SEL_PORT_A)), .wr_data(cap_data),
    .bsr_en(1'b0), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .dir_in(cw[CW_DIR_A]), .pin_in(pa_in), .lat(pa_out), .oe(pa_oe), .rd_val(rd_a)
  );

  ppio_port #(.W(PORT_W), .LSB_IDX(0), .HAS_BSR(1'b0), .SEL_W(SEL_W)) u_pb (
    .clk(clk), .rst(rst), .clear(clearing),
    .wr_en(commit && (cap_addr == SEL_PORT_B)), .wr_data(cap_data),
    .bsr_en(1'b0), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .dir_in(cw[CW_DIR_B]), .pin_in(pb_in), .lat(pb_out), .oe(pb_oe), .rd_val(rd_b)
  );

  assign c_dir = {cw[CW_DIR_CU], cw[CW_DIR_CL]};

  for (genvar n = 0; n < 2; n++) begin : g_pc_nib
    ppio_port #(.W(NIB_W), .LSB_IDX(n * NIB_W), .HAS_BSR(1'b1), .SEL_W(SEL_W)) u_nib (
      .clk(clk), .rst(rst), .clear(clearing),
      .wr_en(commit && (cap_addr == SEL_PORT_C)),
      .wr_data(cap_data[n*NIB_W +: NIB_W]),
      .bsr_en(bsr_en), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
      .dir_in(c_dir[n]), .pin_in(pc_in[n*NIB_W +: NIB_W]),
      .lat(pc_out[n*NIB_W +: NIB_W]), .oe(pc_oe[n]),
      .rd_val(rd_c[n*NIB_W +: NIB_W])
    );
  end

  always_comb begin
    case (s_addr)
      SEL_PORT_A: rd_mux = rd_a;
      SEL_PORT_B: rd_mux = rd_b;
      SEL_PORT_C: rd_mux = rd_c;
      default:    rd_mux = cw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_oe  <= 1'b0;
      d_out <= '0;
    end else begin
      d_oe  <= rd_act;
      d_out <= rd_act ? rd_mux : '0;
    end
  end

  a_r8_bus_idle_unselected: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 2) |-> !d_oe);

  a_r3_pa_enable_is_output: assert property (@(posedge clk) disable iff (rst)
    pa_oe |-> !cw[CW_DIR_A]);

  a_r3_pb_enable_is_output: assert property (@(posedge clk) disable iff (rst)
    pb_oe |-> !cw[CW_DIR_B]);

endmodule

// File: tb/ppio_ctrl_test.sv
module ppio_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] d_in = 8'h00;
  logic [7:0] d_out;
  logic       d_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pb_out, pc_out;
  logic       pa_oe, pb_oe;
  logic [1:0] pc_oe, grp_a_mode;
  logic       grp_b_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0] m_cw, m_a, m_b, m_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppio_ctrl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cw[4] ? pa_in : m_a;
      2'd1: return m_cw[1] ? pb_in : m_b;
      2'd2: return {m_cw[3] ? pc_in[7:4] : m_c[7:4], m_cw[0] ? pc_in[3:0] : m_c[3:0]};
      default: return m_cw;
    endcase
  endfunction

  function automatic logic [1:0] exp_amode(input logic [7:0] cw);
    return cw[6] ? 2'd2 : (cw[5] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [4:0] exp_oes(input logic [7:0] cw);
    return {!cw[4], !cw[1], !cw[3], !cw[0], 1'b0};
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default: begin
        if (d[7]) begin
          m_cw = d; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
        end else begin
          m_c[d[3:1]] = d[0];
        end
      end
    endcase
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; d_in = d; cs_n = 1'b0; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1; cs_n = 1'b1;
    cycles(3);
    model_write(a, d);
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    cycles(3);
    d = d_out; oe = d_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    cycles(3);
  endtask

  task automatic check_ports(input string req);
    chk(pa_out == m_a, req, pa_out, m_a);
    chk(pb_out == m_b, req, pb_out, m_b);
    chk(pc_out == m_c, req, pc_out, m_c);
    chk({pa_oe, pb_oe, pc_oe, 1'b0} == exp_oes(m_cw), req,
        {pa_oe, pb_oe, pc_oe, 1'b0}, exp_oes(m_cw));
  endtask

  task automatic read_check(input logic [1:0] a, input string req);
    logic [7:0] v; logic oe; logic [7:0] e;
    cpu_read(a, v, oe);
    e = exp_read(a);
    chk(oe == 1'b1, "R8 d_oe during read", oe, 1);
    chk(v == e, req, v, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v; logic oe;
    void'($urandom(32'h5EED_0042));
    m_cw = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
    cycles(4);
    rst = 1'b0;
    cycles(2);

    // R1 reset state
    chk(d_oe == 1'b0, "R1 d_oe after reset", d_oe, 0);
    check_ports("R1 ports after reset");
    pa_in = 8'h3C; pb_in = 8'hC3; pc_in = 8'h96;
    read_check(2'd3, "R1 control word reads 9B");

    // R2/R3/R4: all outputs, write each port
    cpu_write(2'd3, 8'h80);
    check_ports("R3 all-output mode word");
    cpu_write(2'd0, 8'h11);
    cpu_write(2'd1, 8'h22);
    cpu_write(2'd2, 8'h33);
    check_ports("R2 port writes by address");
    read_check(2'd0, "R4 read output port A returns latch");
    read_check(2'd1, "R2 read port B");
    read_check(2'd2, "R2 read port C");

    // R4 mixed nibble directions: C upper input, C lower output
    cpu_write(2'd3, 8'h88);
    cpu_write(2'd2, 8'h5A);
    pc_in = 8'hE1;
    read_check(2'd2, "R4 port C mixed nibbles");
    check_ports("R3 C upper input only");

    // R5 chip-select rises first; later data ignored
    cpu_write(2'd3, 8'h80);
    @(negedge clk);
    addr = 2'd0; d_in = 8'hA5; cs_n = 1'b0; wr_n = 1'b0;
    cycles(3);
    cs_n = 1'b1;
    cycles(1);
    d_in = 8'h3C;
    cycles(3);
    wr_n = 1'b1;
    cycles(3);
    m_a = 8'hA5;
    chk(pa_out == 8'hA5, "R5 cs rises first", pa_out, 8'hA5);
    // write strobe rises first, data changes afterwards
    @(negedge clk);
    addr = 2'd1; d_in = 8'h69; cs_n = 1'b0; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1;
    cycles(1);
    d_in = 8'hFF;
    cycles(3);
    cs_n = 1'b1;
    cycles(3);
    m_b = 8'h69;
    chk(pb_out == 8'h69, "R5 wr rises first", pb_out, 8'h69);

    // R6 clear while the mode-set strobe is still low
    @(negedge clk);
    addr = 2'd3; d_in = 8'h80; cs_n = 1'b0; wr_n = 1'b0;
    cycles(3);
    chk(pa_out == 8'h00, "R6 latch cleared while low", pa_out, 0);
    chk(pb_out == 8'h00, "R6 latch B cleared while low", pb_out, 0);
    chk(pa_oe == 1'b0, "R6 enable off while low", pa_oe, 0);
    wr_n = 1'b1; cs_n = 1'b1;
    cycles(3);
    model_write(2'd3, 8'h80);
    check_ports("R6 after mode-set release");

    // R7 bit set/reset of port C
    cpu_write(2'd2, 8'h0F);
    cpu_write(2'd3, 8'h0F); // bit 7 set to 1
    cpu_write(2'd3, 8'h02); // bit 1 cleared
    chk(pc_out == 8'h8D, "R7 bit set/reset on port C", pc_out, 8'h8D);
    read_check(2'd3, "R7 control word unchanged by bit op");

    // R8 bus enable only with cs and rd both low
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
    cycles(3);
    chk(d_oe == 1'b0, "R8 rd without cs", d_oe, 0);
    chk(d_out == 8'h00, "R8 d_out idle", d_out, 0);
    rd_n = 1'b1; cs_n = 1'b0;
    cycles(3);
    chk(d_oe == 1'b0, "R8 cs without rd", d_oe, 0);
    cs_n = 1'b1;
    cycles(2);

    // R9 mode decode
    cpu_write(2'd3, 8'hA4);
    chk(grp_a_mode == 2'd1 && grp_b_mode == 1'b1, "R9 mode 1/1", {grp_a_mode, grp_b_mode}, 3'b011);
    cpu_write(2'd3, 8'hC0);
    chk(grp_a_mode == 2'd2 && grp_b_mode == 1'b0, "R9 mode 2/0", {grp_a_mode, grp_b_mode}, 3'b100);
    cpu_write(2'd3, 8'hE0);
    chk(grp_a_mode == 2'd2, "R9 bits 11 decode to 2", grp_a_mode, 2);
    read_check(2'd3, "R9 stored word reads back");

    // R10 strobes without chip select
    cpu_write(2'd3, 8'h80);
    cpu_write(2'd0, 8'h77);
    @(negedge clk);
    addr = 2'd0; d_in = 8'hFF; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1;
    cycles(3);
    addr = 2'd3; d_in = 8'h9B; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1;
    cycles(3);
    check_ports("R10 unselected writes ignored");

    // random mix against the model
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 6);
      d = 8'($urandom);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      case (op)
        0, 1: cpu_write(2'($urandom % 3), d);
        2: begin
          cpu_write(2'd3, {1'b1, d[6:0]});
          chk(grp_a_mode == exp_amode(m_cw), "R9 random mode decode", grp_a_mode, exp_amode(m_cw));
        end
        3: cpu_write(2'd3, {1'b0, d[6:0]});
        default: read_check(2'($urandom), "R4 random read");
      endcase
      check_ports("R2 random port state");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule